// File: doc/BRIEF.md
# Dual-Channel Serial Controller Register Front End

This block is the host-facing register and interrupt logic of a two-channel serial controller. A processor reaches it over a small byte-wide bus with a two-bit address, read and write strobes, write data and combinational read data. Each channel exposes a control port and a data port. The control port works indirectly. A per-channel register pointer picks which internal register the next control access reaches. The pointer falls back to zero after every register access, so the host always writes a pointer byte first and then the access itself.

Channel index 0 is channel B and index 1 is channel A. A single pending-interrupt register sits in read register 3 of channel A. It gathers a transmit flag and a receive flag for each channel. The interrupt output combines these flags with per-channel enables and one master enable.

On the stream side, each channel takes received bytes through a valid/ready handshake into a one-byte holding register. The ready signal is high exactly when the holding register is empty. A producer holds its valid and data until it sees ready, and a byte offered while the register is full is simply not taken. Transmit bytes leave on a valid strobe that lasts one cycle and has no ready. The sink must take every strobe.

Top module: `dual_serial_regs`

## Requirements
- R1: Bus address bit 0 selects the port: 0 is the control port and 1 is the data port. Address bit 1 selects the channel: 0 is channel B and 1 is channel A. Read and write strobes are never high together.
- R2: A control write while the channel's pointer is zero loads the pointer. A byte below 16 loads its low 4 bits, and any larger byte loads only its low 3 bits.
- R3: With the pointer nonzero, a control write stores the byte into the selected write register. Write register 1 holds transmit-interrupt-enable at bit 1 and receive-interrupt mode at bits 4:3. Write register 9 of channel A holds master enable at bit 3. A control read returns the selected read register, and read registers other than 0, and 3 of channel A, read as 0. Either kind of control access returns the pointer to zero.
- R4: A control write with the pointer at zero and bits 7:3 equal to 00111 (0x38 to 0x3F) clears the whole pending register. That register is read register 3 of channel A; read register 3 of channel B reads 0.
- R5: Read register 0 of each channel has receive-ready at bit 0. Transmit-empty (bit 2), carrier-detect (bit 3) and clear-to-send (bit 5) always read 1, and all other bits read 0, giving 0x2C or 0x2D.
- R6: A data write sets that channel's transmit-pending bit: bit 1 for channel B, bit 4 for channel A. A nonzero byte also appears on the channel's transmit data with a one-cycle valid strobe in the next cycle. A zero byte is not sent.
- R7: Receive ready is high only while the channel's holding register is empty, and a byte is taken when valid and ready are both high. A data read returns the held byte, or 0 if none is held, and empties the register.
- R8: Every cycle, the receive-pending bits (bit 2 for channel B, bit 5 for channel A) are re-derived from whether each channel still holds a byte. They are forced to 0 while any channel has its transmit-pending bit and its transmit-interrupt-enable both set. A set receive-pending bit sets that channel's receive-ready bit, and a data read clears it.
- R9: The interrupt output is high when master enable is set and some channel has either transmit-pending with transmit-interrupt-enable, or receive-pending with nonzero receive-interrupt mode. With master enable clear it is low.
- R10: After reset the pointers, write registers, pending bits, held bytes, transmit strobes and the interrupt output are all zero, and both receive-ready outputs are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Bit 0 port select, bit 1 channel select |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| irq | output | 1 | Interrupt request |
| rx_data | input | 16 | Receive bytes, [7:0] channel B, [15:8] channel A |
| rx_valid | input | 2 | Receive byte offered, per channel |
| rx_ready | output | 2 | Holding register empty, per channel |
| tx_data | output | 16 | Transmit bytes, [7:0] channel B, [15:8] channel A |
| tx_valid | output | 2 | One-cycle transmit strobe, per channel |

## Verification
The bench goes after the two pointer widths. A design that kept four bits from 0x1B would land on register 11 and read 0 instead of the pending byte. It also checks that 0x3F both clears the pending register and leaves the pointer at 7; a design that got this wrong would either miss the clear or make the next write land elsewhere. It checks that a transmit interrupt suppresses receive-pending and that the receive flag returns after a clear; a design without this gating would show bit 5 alongside bit 1. It also sends a zero data byte, which must set the pending bit with no transmit strobe, and offers a byte to a full holding register, which a careless design would use to overwrite the held byte.

// File: rtl/sccr_pkg.sv
package sccr_pkg;
  localparam int NCH = 2;
  localparam int DW  = 8;
  localparam int PW  = 4;
  localparam int CODE_LSB = 3;

  // read register 0 layout
  localparam int RR0_RXRDY = 0;
  localparam logic [DW-1:0] RR0_FIXED = 8'h2C;

  // pending register layout: transmit and receive bit per channel
  localparam int PEND_TX_B = 1;
  localparam int PEND_RX_B = 2;
  localparam int PEND_TX_A = 4;
  localparam int PEND_RX_A = 5;

  // write register fields
  localparam logic [PW-1:0] WREG_IEN = 4'd1;
  localparam logic [PW-1:0] WREG_MST = 4'd9;
  localparam logic [PW-1:0] RREG_PND = 4'd3;
  localparam int IEN_TIE     = 1;
  localparam int IEN_RIE_LSB = 3;
  localparam int MST_MIE     = 3;

  localparam logic [DW-1-CODE_LSB:0] CLR_CODE = 5'b00111;

  typedef struct packed {
    logic ctl_wr;
    logic ctl_rd;
    logic dat_wr;
    logic dat_rd;
  } acc_t;
endpackage

// File: rtl/sccr_decode.sv
module sccr_decode
  import sccr_pkg::*;
(
  input  logic [1:0]          bus_addr,
  input  logic                bus_rd,
  input  logic                bus_wr,
  output acc_t [NCH-1:0]      acc
);
  for (genvar c = 0; c < NCH; c++) begin : g_dec
    logic hit;
    assign hit = (bus_addr[1] == c[0]);
    always_comb begin
      acc[c].ctl_wr = hit & bus_wr & ~bus_addr[0];
      acc[c].ctl_rd = hit & bus_rd & ~bus_wr & ~bus_addr[0];
      acc[c].dat_wr = hit & bus_wr & bus_addr[0];
      acc[c].dat_rd = hit & bus_rd & ~bus_wr & bus_addr[0];
    end
  end
endmodule

// File: rtl/sccr_channel.sv
module sccr_channel
  import sccr_pkg::*;
#(
  parameter bit IS_A = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  acc_t          acc,
  input  logic [DW-1:0] wdata,
  input  logic          rx_set,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_valid,
  output logic          rx_ready,
  output logic [DW-1:0] tx_data,
  output logic          tx_valid,
  output logic [DW-1:0] rd_byte,
  output logic          tie,
  output logic [1:0]    rie,
  output logic          mie,
  output logic          rx_avail,
  output logic          clr_cmd,
  output logic [PW-1:0] ptr
);
  logic [PW-1:0] ptr_q;
  logic          ptr_zero;
  logic [PW-1:0] ptr_load;
  logic          rxrdy_q;
  logic          full_q;
  logic [DW-1:0] hold_q;
  logic          tie_q;
  logic [1:0]    rie_q;
  logic [DW-1:0] tx_q;
  logic          txv_q;
  logic          accept;

  assign ptr_zero = (ptr_q == '0);
  assign ptr_load = (wdata[DW-1:PW] == '0) ? wdata[PW-1:0]
                                           : {1'b0, wdata[PW-2:0]};
  assign clr_cmd  = acc.ctl_wr & ptr_zero &
                    (wdata[DW-1:CODE_LSB] == CLR_CODE);

  // register pointer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (acc.ctl_wr && ptr_zero) begin
      ptr_q <= ptr_load;
    end else if (acc.ctl_wr || acc.ctl_rd) begin
      ptr_q <= '0;
    end
  end

  // interrupt enable register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tie_q <= 1'b0;
      rie_q <= '0;
    end else if (acc.ctl_wr && ptr_q == WREG_IEN) begin
      tie_q <= wdata[IEN_TIE];
      rie_q <= wdata[IEN_RIE_LSB +: 2];
    end
  end

  // master enable lives in channel A only
  if (IS_A) begin : g_mst
    logic mie_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mie_q <= 1'b0;
      end else if (acc.ctl_wr && ptr_q == WREG_MST) begin
        mie_q <= wdata[MST_MIE];
      end
    end
    assign mie = mie_q;
  end else begin : g_nomst
    assign mie = 1'b0;
  end

  // receive holding register
  assign rx_ready = ~full_q;
  assign accept   = rx_valid & ~full_q;
  assign rx_avail = full_q & ~acc.dat_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      hold_q <= '0;
    end else if (accept) begin
      full_q <= 1'b1;
      hold_q <= rx_data;
    end else if (acc.dat_rd) begin
      full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxrdy_q <= 1'b0;
    end else if (rx_set) begin
      rxrdy_q <= 1'b1;
    end else if (acc.dat_rd) begin
      rxrdy_q <= 1'b0;
    end
  end

  // transmit strobe
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txv_q <= 1'b0;
      tx_q  <= '0;
    end else begin
      txv_q <= acc.dat_wr & (wdata != '0);
      if (acc.dat_wr && wdata != '0) tx_q <= wdata;
    end
  end

  // read mux for read register 0 and the data port
  always_comb begin
    rd_byte = '0;
    if (acc.ctl_rd && ptr_zero) begin
      rd_byte = RR0_FIXED;
      rd_byte[RR0_RXRDY] = rxrdy_q;
    end else if (acc.dat_rd && full_q) begin
      rd_byte = hold_q;
    end
  end

  assign tie      = tie_q;
  assign rie      = rie_q;
  assign tx_data  = tx_q;
  assign tx_valid = txv_q;
  assign ptr      = ptr_q;
endmodule

// File: rtl/sccr_pending.sv
module sccr_pending
  import sccr_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] tx_set,
  input  logic           clr,
  input  logic [NCH-1:0] rx_avail,
  input  logic [NCH-1:0] tie,
  input  logic [NCH-1:0] rie_any,
  input  logic           mie,
  output logic [NCH-1:0] rx_set,
  output logic [DW-1:0]  pend,
  output logic           irq
);
  logic [NCH-1:0] tx_q, rx_q, tx_after, rx_next;
  logic           tx_active;

  assign tx_after  = (clr ? '0 : tx_q) | tx_set;
  assign tx_active = |(tx_after & tie);
  assign rx_next   = tx_active ? '0 : rx_avail;
  assign rx_set    = rx_next;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      tx_q <= tx_after;
      rx_q <= rx_next;
    end
  end

  always_comb begin
    pend = '0;
    pend[PEND_TX_B] = tx_q[0];
    pend[PEND_RX_B] = rx_q[0];
    pend[PEND_TX_A] = tx_q[1];
    pend[PEND_RX_A] = rx_q[1];
  end

  assign irq = mie & (|(tx_q & tie) | |(rx_q & rie_any));
endmodule

// File: rtl/dual_serial_regs.sv
module dual_serial_regs
  import sccr_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          bus_addr,
  input  logic                bus_rd,
  input  logic                bus_wr,
  input  logic [DW-1:0]       bus_wdata,
  output logic [DW-1:0]       bus_rdata,
  output logic                irq,
  input  logic [NCH*DW-1:0]   rx_data,
  input  logic [NCH-1:0]      rx_valid,
  output logic [NCH-1:0]      rx_ready,
  output logic [NCH*DW-1:0]   tx_data,
  output logic [NCH-1:0]      tx_valid
);
  acc_t [NCH-1:0]     acc;
  logic [NCH-1:0]     tie, rie_any, mie, rx_avail, clr_cmd, rx_set, dat_wr;
  logic [NCH*DW-1:0]  rd_flat;
  logic [NCH*PW-1:0]  ptr_flat;
  logic [DW-1:0]      pend_byte;
  logic               mie_any;
  logic               pend_sel;

  sccr_decode u_dec (
    .bus_addr (bus_addr),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .acc      (acc)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [1:0] rie;
    sccr_channel #(.IS_A(c == 1)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .acc      (acc[c]),
      .wdata    (bus_wdata),
      .rx_set   (rx_set[c]),
      .rx_data  (rx_data[c*DW +: DW]),
      .rx_valid (rx_valid[c]),
      .rx_ready (rx_ready[c]),
      .tx_data  (tx_data[c*DW +: DW]),
      .tx_valid (tx_valid[c]),
      .rd_byte  (rd_flat[c*DW +: DW]),
      .tie      (tie[c]),
      .rie      (rie),
      .mie      (mie[c]),
      .rx_avail (rx_avail[c]),
      .clr_cmd  (clr_cmd[c]),
      .ptr      (ptr_flat[c*PW +: PW])
    );
    assign rie_any[c] = |rie;
    assign dat_wr[c]  = acc[c].dat_wr;
  end

  assign mie_any = |mie;

  sccr_pending u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_set   (dat_wr),
    .clr      (|clr_cmd),
    .rx_avail (rx_avail),
    .tie      (tie),
    .rie_any  (rie_any),
    .mie      (mie_any),
    .rx_set   (rx_set),
    .pend     (pend_byte),
    .irq      (irq)
  );

  assign pend_sel  = acc[1].ctl_rd & (ptr_flat[PW +: PW] == RREG_PND);
  assign bus_rdata = pend_sel ? pend_byte : (rd_flat[0 +: DW] | rd_flat[DW +: DW]);
endmodule

// File: rtl/sccr_checker.sv
module sccr_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  bus_addr,
  input logic        bus_rd,
  input logic        bus_wr,
  input logic [7:0]  bus_wdata,
  input logic [7:0]  bus_rdata,
  input logic        irq,
  input logic [1:0]  rx_ready,
  input logic [1:0]  tx_valid,
  input logic [15:0] tx_data,
  input logic [7:0]  ptr_flat,
  input logic [7:0]  pend,
  input logic        mie_a
);
  logic [3:0] ptr_sel;
  assign ptr_sel = bus_addr[1] ? ptr_flat[7:4] : ptr_flat[3:0];

  AST_PTR_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rd || bus_wr) && !bus_addr[0] && ptr_sel != 4'd0)
    |=> (($past(bus_addr[1]) ? ptr_flat[7:4] : ptr_flat[3:0]) == 4'd0)); // R3

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !mie_a |-> !irq); // R9

  AST_TXB_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid[0] |-> tx_data[7:0] != 8'h00); // R6

  AST_TXA_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid[1] |-> tx_data[15:8] != 8'h00); // R6

  AST_RXB_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_ready[0] && !(bus_rd && bus_addr == 2'b01)) |=> !rx_ready[0]); // R7

  AST_RXA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_ready[1] && !(bus_rd && bus_addr == 2'b11)) |=> !rx_ready[1]); // R7

  AST_RR0_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && !bus_addr[0] && ptr_sel == 4'd0)
    |-> ((bus_rdata & 8'hFE) == 8'h2C)); // R5

  AST_CLR_TX: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_addr[0] && ptr_sel == 4'd0 && bus_wdata[7:3] == 5'b00111)
    |=> (pend[1] == 1'b0 && pend[4] == 1'b0)); // R4
endmodule

bind dual_serial_regs sccr_checker chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .rx_ready  (rx_ready),
  .tx_valid  (tx_valid),
  .tx_data   (tx_data),
  .ptr_flat  (ptr_flat),
  .pend      (pend_byte),
  .mie_a     (mie_any)
);

// File: tb/dual_serial_regs_tb_top.sv
module dual_serial_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        irq;
  logic [15:0] rx_data = '0;
  logic [1:0]  rx_valid = '0;
  logic [1:0]  rx_ready;
  logic [15:0] tx_data;
  logic [1:0]  tx_valid;

  int nchk = 0;
  int nbad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dual_serial_regs dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_data(tx_data), .tx_valid(tx_valid)
  );

  // {op (0 write, 1 read-and-compare), addr, data, expected}
  localparam int NV = 19;
  localparam logic [19:0] VEC [NV] = '{
    {2'd1, 2'd0, 8'h00, 8'h2C},  // R5 R10 channel B status at reset
    {2'd1, 2'd2, 8'h00, 8'h2C},  // R5 channel A status
    {2'd0, 2'd2, 8'h03, 8'h00},  // R2 pointer to 3
    {2'd1, 2'd2, 8'h00, 8'h00},  // R3 pending empty
    {2'd0, 2'd1, 8'h41, 8'h00},  // R6 data byte on channel B
    {2'd0, 2'd2, 8'h1B, 8'h00},  // R2 large byte keeps 3 bits -> 3
    {2'd1, 2'd2, 8'h00, 8'h02},  // R6 channel B transmit pending
    {2'd0, 2'd2, 8'h0B, 8'h00},  // R2 small byte keeps 4 bits -> 11
    {2'd1, 2'd2, 8'h00, 8'h00},  // R3 register 11 reads 0
    {2'd0, 2'd0, 8'h03, 8'h00},  // R4 channel B pointer 3
    {2'd1, 2'd0, 8'h00, 8'h00},  // R4 channel B register 3 reads 0
    {2'd1, 2'd2, 8'h00, 8'h2C},  // R3 pointer back at zero
    {2'd0, 2'd3, 8'h00, 8'h00},  // R6 zero byte on channel A
    {2'd0, 2'd2, 8'h03, 8'h00},  // R1 address decode
    {2'd1, 2'd2, 8'h00, 8'h12},  // R6 both transmit bits
    {2'd0, 2'd2, 8'h3F, 8'h00},  // R4 clear code, pointer becomes 7
    {2'd1, 2'd2, 8'h00, 8'h00},  // R3 register 7 reads 0
    {2'd0, 2'd2, 8'h03, 8'h00},  // R4
    {2'd1, 2'd2, 8'h00, 8'h00}   // R4 pending cleared
  };

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    nchk++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic do_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #2 d = bus_rdata;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic feed(input int ch, input logic [7:0] b);
    @(negedge clk);
    rx_valid[ch] = 1'b1; rx_data[ch*8 +: 8] = b;
    @(posedge clk); #1;
    rx_valid[ch] = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      nchk++; nbad++;
      $display("FAIL watchdog actual=%h expected=%h", 1'b0, 1'b1);
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R10 irq", {7'd0, irq}, 8'h00);
    chk("R10 rx_ready", {6'd0, rx_ready}, 8'h03);
    chk("R10 tx_valid", {6'd0, tx_valid}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][19:18] == 2'd0) begin
        do_wr(VEC[i][17:16], VEC[i][15:8]);
        if (VEC[i][17:16] == 2'd1) chk("R6 strobe B", {tx_valid[0], tx_data[6:0]}, {1'b1, VEC[i][14:8]});
        if (VEC[i][17:16] == 2'd3) chk("R6 zero byte not sent", {7'd0, tx_valid[1]}, 8'h00);
      end else begin
        do_rd(VEC[i][17:16], r);
        chk($sformatf("R3 vector %0d", i), r, VEC[i][7:0]);
      end
    end

    // R6 strobe lasts one cycle
    do_wr(2'd3, 8'hA5);
    chk("R6 A byte", tx_data[15:8], 8'hA5);
    chk("R6 A strobe", {7'd0, tx_valid[1]}, 8'h01);
    @(posedge clk); #1;
    chk("R6 strobe one cycle", {6'd0, tx_valid}, 8'h00);
    do_wr(2'd2, 8'h38);

    // R7 receive handshake and back-pressure
    feed(1, 8'h5A);
    chk("R7 full drops ready", {7'd0, rx_ready[1]}, 8'h00);
    @(negedge clk); rx_valid[1] = 1'b1; rx_data[15:8] = 8'h77;
    @(posedge clk); #1; rx_valid[1] = 1'b0;
    do_rd(2'd2, r);
    chk("R8 rx ready bit", r, 8'h2D);
    do_wr(2'd2, 8'h03);
    do_rd(2'd2, r);
    chk("R8 rx pending A", r, 8'h20);
    do_rd(2'd3, r);
    chk("R7 held byte kept", r, 8'h5A);
    chk("R7 ready after read", {7'd0, rx_ready[1]}, 8'h01);
    do_rd(2'd3, r);
    chk("R7 empty reads zero", r, 8'h00);
    do_rd(2'd2, r);
    chk("R8 ready bit cleared", r, 8'h2C);

    // R9 interrupt gating
    do_wr(2'd2, 8'h09); do_wr(2'd2, 8'h08);
    do_wr(2'd0, 8'h01); do_wr(2'd0, 8'h02);
    chk("R9 idle", {7'd0, irq}, 8'h00);
    do_wr(2'd1, 8'h31);
    chk("R9 tx irq", {7'd0, irq}, 8'h01);
    do_wr(2'd2, 8'h38);
    chk("R4 clear drops irq", {7'd0, irq}, 8'h00);
    do_wr(2'd2, 8'h01); do_wr(2'd2, 8'h10);
    feed(1, 8'h66);
    @(posedge clk); #1;
    chk("R9 rx irq", {7'd0, irq}, 8'h01);
    do_wr(2'd1, 8'h22);
    do_wr(2'd2, 8'h03);
    do_rd(2'd2, r);
    chk("R8 tx hides rx", r, 8'h02);
    chk("R9 irq via tx", {7'd0, irq}, 8'h01);
    do_wr(2'd2, 8'h09); do_wr(2'd2, 8'h00);
    chk("R9 master off", {7'd0, irq}, 8'h00);
    do_wr(2'd2, 8'h38);
    do_wr(2'd2, 8'h03);
    do_rd(2'd2, r);
    chk("R8 rx back after clear", r, 8'h20);
    do_rd(2'd3, r);
    chk("R7 second byte", r, 8'h66);

    // R10 reset mid-run
    feed(0, 8'h11);
    do_wr(2'd2, 8'h05);
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #1; rst_n = 1'b1;
    chk("R10 rx_ready after reset", {6'd0, rx_ready}, 8'h03);
    chk("R10 irq after reset", {7'd0, irq}, 8'h00);
    do_rd(2'd2, r);
    chk("R10 pointer zeroed", r, 8'h2C);
    do_rd(2'd1, r);
    chk("R10 held byte gone", r, 8'h00);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule